// File: doc/BRIEF.md
# Real-Time Clock Register and Interrupt Unit

This block is a memory-mapped real-time clock on a 32-bit register bus with single-cycle read and write strobes and a word index for the address. A 16-bit prescaler counts clock cycles from zero up to a parameter value and then wraps. Each wrap is one tick, and each tick advances a 32-bit seconds counter. Software sets the time by writing a load register. The value waits there and replaces the increment at the next tick, so the seconds boundary never shifts.

Two event sources feed a two-bit event status word: a per-tick event, and an alarm match when the seconds counter reaches the alarm register. A second, one-bit status word records accesses to unmapped words in the register window. Software cannot write either status word's mask directly. An unmask port clears mask bits and a mask-set port sets them. Each status word drives its own interrupt line, which is high whenever a status bit is set while its mask bit is clear.

Top module: `rtc_regunit`

## Requirements
- R1: After reset the seconds counter, the prescaler count and both status words are zero. The event mask is 2'b11, the error mask is 1, the control word is 0x0100_0000, and both interrupt outputs are low.
- R2: Read data is combinational from bus_addr. The word indices are: 0 live seconds (read-only); 1 time load (write; reads the live seconds); 2 prescaler count (read-only, 16 bits); 3 trim readback (read-only, the low 21 bits of TRIM_VAL, upper bits zero); 4 alarm (read/write); 5 event status; 6 event mask (read-only); 7 event unmask; 8 event mask-set; 9 error status; 10 error mask (read-only); 11 error unmask; 12 error mask-set; 13 control.
- R3: The prescaler counts from 0 to PRESC_MAX and returns to 0. The cycle in which it holds PRESC_MAX is a tick, and a tick adds one to the seconds counter, with 0xFFFF_FFFF wrapping to 0. The seconds counter holds its value in every other cycle.
- R4: A write to word 1 stores the value. At the next tick the seconds counter takes that value in place of the increment.
- R5: Event status bit 0 sets on every tick. Event status bit 1 sets on a tick whose new seconds value equals the alarm register.
- R6: Writing word 5 clears the event status bits where the write data has ones and leaves the bits where it has zeros. A set condition in the same cycle as the clear wins.
- R7: A write to a mask word leaves it unchanged. Writing word 7 clears event mask bits where the data has ones, and writing word 8 sets them. Words 7 and 8 read as zero.
- R8: irq_time is high in every cycle that some event status bit is set while its mask bit is clear. It follows status and mask changes one clock edge after the causing write or tick.
- R9: A read or write to word 14 or 15 sets error status bit 0, and such a read returns zero.
- R10: Error status bit 0 clears when written with a one and holds when written with a zero. Words 11 and 12 clear and set the error mask bit and read as zero. irq_buserr is high while the error status is set and the error mask is clear.
- R11: Only control bits 31, 27:24 and 0 take writes. All other control bits read as zero.
- R12: Writes to the read-only words 0, 2, 3, 6 and 10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word index in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_time | output | 1 | Event interrupt |
| irq_buserr | output | 1 | Address-error interrupt |

## Verification
The register walk runs before the first tick, so every read value is fixed. It writes all ones and all zeros to the control word, which separates the writable control bits from the reserved ones. Writes of zero, one and all ones to the mask, unmask and status words separate set, clear, no-effect and write-one-to-clear behaviour. The timed tests synchronise on the prescaler count read back over the bus. They place a status clear in the tick cycle itself, load a new time while a tick is pending, match the alarm against a loaded value, and load 0xFFFF_FFFF so that the seconds counter wraps. Together these separate increment from load, alarm events from tick events, and set priority from clear.

// File: rtl/rtc_regunit_pkg.sv
package rtc_regunit_pkg;
    localparam int REG_AW = 4;
    localparam int DATA_W = 32;
    localparam int EV_W   = 2;
    localparam int TICK_W = 16;
    localparam int TRIM_W = 21;

    typedef logic [REG_AW-1:0] reg_idx_t;

    localparam reg_idx_t IX_TIME_NOW   = 4'd0;
    localparam reg_idx_t IX_TIME_LOAD  = 4'd1;
    localparam reg_idx_t IX_TICK_NOW   = 4'd2;
    localparam reg_idx_t IX_TRIM_RB    = 4'd3;
    localparam reg_idx_t IX_ALARM      = 4'd4;
    localparam reg_idx_t IX_EV_STAT    = 4'd5;
    localparam reg_idx_t IX_EV_MASK    = 4'd6;
    localparam reg_idx_t IX_EV_UNMASK  = 4'd7;
    localparam reg_idx_t IX_EV_MASKSET = 4'd8;
    localparam reg_idx_t IX_ER_STAT    = 4'd9;
    localparam reg_idx_t IX_ER_MASK    = 4'd10;
    localparam reg_idx_t IX_ER_UNMASK  = 4'd11;
    localparam reg_idx_t IX_ER_MASKSET = 4'd12;
    localparam reg_idx_t IX_CTRL       = 4'd13;

    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0100_0000;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h8F00_0001;

    function automatic logic idx_mapped(input reg_idx_t ix);
        return ix <= IX_CTRL;
    endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int          CNT_W   = 16,
    parameter int unsigned WRAP_AT = 32767
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP_AT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == LAST) s_d.cnt = '0;
        else                 s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o  = (s_q.cnt == LAST);
    assign count_o = s_q.cnt;
endmodule

// File: rtl/rtc_sec_keeper.sv
module rtc_sec_keeper #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_wr_i,
    input  logic [SEC_W-1:0] load_val_i,
    input  logic [SEC_W-1:0] alarm_i,
    output logic [SEC_W-1:0] sec_o,
    output logic             alarm_hit_o
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic             pend;
        logic [SEC_W-1:0] hold;
    } st_t;

    st_t              s_d, s_q;
    logic [SEC_W-1:0] nxt;

    always_comb begin
        s_d = s_q;
        nxt = s_q.pend ? s_q.hold : s_q.sec + 1'b1;
        if (tick_i) begin
            s_d.sec  = nxt;
            s_d.pend = 1'b0;
        end
        // a load written in a tick cycle waits for the following tick
        if (load_wr_i) begin
            s_d.pend = 1'b1;
            s_d.hold = load_val_i;
        end
        alarm_hit_o = tick_i && (nxt == alarm_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sec_o = s_q.sec;
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic         unmask_wr_i,
    input  logic         maskset_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] mask;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_wr_i)     s_d.status = s_q.status & ~wdata_i;
        s_d.status = s_d.status | set_i;          // R6: set wins
        if (unmask_wr_i)  s_d.mask = s_q.mask & ~wdata_i;
        if (maskset_wr_i) s_d.mask = s_q.mask | wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.status <= '0;
            s_q.mask   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.status;
    assign mask_o   = s_q.mask;
    assign irq_o    = |(s_q.status & ~s_q.mask);
endmodule

// File: rtl/rtc_regunit.sv
module rtc_regunit
    import rtc_regunit_pkg::*;
#(
    parameter int unsigned       PRESC_MAX = 32767,
    parameter logic [DATA_W-1:0] TRIM_VAL  = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_time,
    output logic              irq_buserr
);
    typedef struct packed {
        logic [DATA_W-1:0] alarm;
        logic [DATA_W-1:0] ctrl;
    } top_st_t;

    top_st_t           r_d, r_q;
    logic              tick;
    logic [TICK_W-1:0] tick_cnt;
    logic [DATA_W-1:0] sec_now;
    logic              alarm_hit;
    logic [EV_W-1:0]   ev_status, ev_mask;
    logic [0:0]        err_status, err_mask;
    logic              unmapped_acc;

    assign unmapped_acc = (bus_wr || bus_rd) && !idx_mapped(bus_addr);

    rtc_tick_gen #(.CNT_W(TICK_W), .WRAP_AT(PRESC_MAX)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick), .count_o(tick_cnt)
    );

    rtc_sec_keeper #(.SEC_W(DATA_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .load_wr_i(bus_wr && bus_addr == IX_TIME_LOAD),
        .load_val_i(bus_wdata), .alarm_i(r_q.alarm),
        .sec_o(sec_now), .alarm_hit_o(alarm_hit)
    );

    rtc_irq_bank #(.W(EV_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .set_i({alarm_hit, tick}),
        .clr_wr_i(bus_wr && bus_addr == IX_EV_STAT),
        .unmask_wr_i(bus_wr && bus_addr == IX_EV_UNMASK),
        .maskset_wr_i(bus_wr && bus_addr == IX_EV_MASKSET),
        .wdata_i(bus_wdata[EV_W-1:0]),
        .status_o(ev_status), .mask_o(ev_mask), .irq_o(irq_time)
    );

    rtc_irq_bank #(.W(1)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(unmapped_acc),
        .clr_wr_i(bus_wr && bus_addr == IX_ER_STAT),
        .unmask_wr_i(bus_wr && bus_addr == IX_ER_UNMASK),
        .maskset_wr_i(bus_wr && bus_addr == IX_ER_MASKSET),
        .wdata_i(bus_wdata[0:0]),
        .status_o(err_status), .mask_o(err_mask), .irq_o(irq_buserr)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr && bus_addr == IX_ALARM) r_d.alarm = bus_wdata;
        if (bus_wr && bus_addr == IX_CTRL)  r_d.ctrl  = bus_wdata & CTRL_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.alarm <= '0;
            r_q.ctrl  <= CTRL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            IX_TIME_NOW,
            IX_TIME_LOAD: bus_rdata = sec_now;
            IX_TICK_NOW:  bus_rdata = DATA_W'(tick_cnt);
            IX_TRIM_RB:   bus_rdata = DATA_W'(TRIM_VAL[TRIM_W-1:0]);
            IX_ALARM:     bus_rdata = r_q.alarm;
            IX_EV_STAT:   bus_rdata = DATA_W'(ev_status);
            IX_EV_MASK:   bus_rdata = DATA_W'(ev_mask);
            IX_ER_STAT:   bus_rdata = DATA_W'(err_status);
            IX_ER_MASK:   bus_rdata = DATA_W'(err_mask);
            IX_CTRL:      bus_rdata = r_q.ctrl;
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_regunit_chk.sv
module rtc_regunit_chk
    import rtc_regunit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_AW-1:0] bus_addr,
    input logic [1:0]        wd_lo,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_time,
    input logic              irq_buserr,
    input logic              tick,
    input logic [DATA_W-1:0] sec_now,
    input logic [EV_W-1:0]   ev_status,
    input logic [EV_W-1:0]   ev_mask,
    input logic [0:0]        err_status
);
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sec_now));

    a_r5_tick_sets_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ev_status[0]);

    a_r6_clear_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IX_EV_STAT && wd_lo[0] && !tick) |=> !ev_status[0]);

    a_r7_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IX_EV_UNMASK && wd_lo == 2'b11) |=> ev_mask == 2'b00);

    a_r7_maskset_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IX_EV_MASKSET && wd_lo == 2'b11) |=> !irq_time && ev_mask == 2'b11);

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !idx_mapped(bus_addr)) |-> bus_rdata == '0);

    a_r9_unmapped_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !idx_mapped(bus_addr)) |=> err_status[0]);

    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IX_ER_STAT && wd_lo[0]) |=> !irq_buserr);

    a_r11_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == IX_CTRL) |-> (bus_rdata & 32'h70FF_FFFE) == '0);
endmodule

bind rtc_regunit rtc_regunit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .wd_lo(bus_wdata[1:0]), .bus_rdata(bus_rdata),
    .irq_time(irq_time), .irq_buserr(irq_buserr), .tick(tick),
    .sec_now(sec_now), .ev_status(ev_status), .ev_mask(ev_mask),
    .err_status(err_status)
);

// File: tb/rtc_regunit_test.sv
module rtc_regunit_test;
    localparam int unsigned PMAX = 499;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_time, irq_buserr;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    rtc_regunit #(.PRESC_MAX(PMAX), .TRIM_VAL(32'hFFFF_FFFF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_time(irq_time), .irq_buserr(irq_buserr)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [3:0]  a;
        logic [31:0] wd;
        logic [31:0] erd;
        logic        te;
        logic        be;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,4'd13,32'h0,        32'h0100_0000,1'b0,1'b0,4'd1},  // R1 control reset
        '{1'b0,1'b1,4'd6, 32'h0,        32'h3,        1'b0,1'b0,4'd1},  // R1 event mask
        '{1'b0,1'b1,4'd10,32'h0,        32'h1,        1'b0,1'b0,4'd1},  // R1 error mask
        '{1'b0,1'b1,4'd5, 32'h0,        32'h0,        1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,4'd9, 32'h0,        32'h0,        1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,4'd0, 32'h0,        32'h0,        1'b0,1'b0,4'd1},  // R1 seconds
        '{1'b1,1'b0,4'd13,32'hFFFF_FFFF,32'h0,        1'b0,1'b0,4'd11}, // R11
        '{1'b0,1'b1,4'd13,32'h0,        32'h8F00_0001,1'b0,1'b0,4'd11}, // R11
        '{1'b1,1'b0,4'd13,32'h0,        32'h0,        1'b0,1'b0,4'd11},
        '{1'b0,1'b1,4'd13,32'h0,        32'h0,        1'b0,1'b0,4'd11},
        '{1'b1,1'b0,4'd6, 32'h0,        32'h0,        1'b0,1'b0,4'd7},  // R7 direct write
        '{1'b0,1'b1,4'd6, 32'h0,        32'h3,        1'b0,1'b0,4'd7},
        '{1'b1,1'b0,4'd7, 32'h1,        32'h0,        1'b0,1'b0,4'd7},  // R7 unmask
        '{1'b0,1'b1,4'd6, 32'h0,        32'h2,        1'b0,1'b0,4'd7},
        '{1'b0,1'b1,4'd7, 32'h0,        32'h0,        1'b0,1'b0,4'd7},
        '{1'b1,1'b0,4'd8, 32'hFFFF_FFFF,32'h0,        1'b0,1'b0,4'd7},  // R7 mask-set
        '{1'b0,1'b1,4'd6, 32'h0,        32'h3,        1'b0,1'b0,4'd7},
        '{1'b0,1'b1,4'd8, 32'h0,        32'h0,        1'b0,1'b0,4'd7},
        '{1'b1,1'b0,4'd4, 32'h1234_5678,32'h0,        1'b0,1'b0,4'd2},  // R2 alarm
        '{1'b0,1'b1,4'd4, 32'h0,        32'h1234_5678,1'b0,1'b0,4'd2},
        '{1'b0,1'b1,4'd3, 32'h0,        32'h001F_FFFF,1'b0,1'b0,4'd2},  // R2 trim width
        '{1'b1,1'b0,4'd0, 32'hDEAD_BEEF,32'h0,        1'b0,1'b0,4'd12}, // R12
        '{1'b0,1'b1,4'd0, 32'h0,        32'h0,        1'b0,1'b0,4'd12},
        '{1'b0,1'b1,4'd1, 32'h0,        32'h0,        1'b0,1'b0,4'd2},
        '{1'b0,1'b1,4'd14,32'h0,        32'h0,        1'b0,1'b0,4'd9},  // R9 masked
        '{1'b0,1'b1,4'd9, 32'h0,        32'h1,        1'b0,1'b0,4'd9},
        '{1'b1,1'b0,4'd11,32'h1,        32'h0,        1'b0,1'b1,4'd10}, // R10
        '{1'b0,1'b1,4'd10,32'h0,        32'h0,        1'b0,1'b1,4'd10},
        '{1'b1,1'b0,4'd9, 32'h0,        32'h0,        1'b0,1'b1,4'd10},
        '{1'b1,1'b0,4'd9, 32'h1,        32'h0,        1'b0,1'b0,4'd10},
        '{1'b1,1'b0,4'd15,32'h0,        32'h0,        1'b0,1'b1,4'd9},  // R9 write
        '{1'b1,1'b0,4'd12,32'h1,        32'h0,        1'b0,1'b0,4'd10},
        '{1'b0,1'b1,4'd9, 32'h0,        32'h1,        1'b0,1'b0,4'd10},
        '{1'b1,1'b0,4'd9, 32'h1,        32'h0,        1'b0,1'b0,4'd10},
        '{1'b0,1'b1,4'd9, 32'h0,        32'h0,        1'b0,1'b0,4'd10},
        '{1'b0,1'b1,4'd11,32'h0,        32'h0,        1'b0,1'b0,4'd10},
        '{1'b0,1'b1,4'd12,32'h0,        32'h0,        1'b0,1'b0,4'd10}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        idle();
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
        step();
        idle();
    endtask

    // returns at the falling edge before the tick edge, bus idle
    task automatic sync_tick();
        for (int i = 0; i < 2000; i++) begin
            bus_rd = 1'b1; bus_addr = 4'd2;
            #1;
            if (bus_rdata == 32'(PMAX)) begin
                idle();
                return;
            end
            step();
        end
        idle();
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_time after reset", 32'(irq_time), 0);
        chk("R1 irq_buserr after reset", 32'(irq_buserr), 0);

        for (int i = 0; i < NV; i++) begin
            bus_wr = VEC[i].wr; bus_rd = VEC[i].rd;
            bus_addr = VEC[i].a; bus_wdata = VEC[i].wd;
            #1;
            if (VEC[i].rd)
                chk($sformatf("table[%0d] R%0d rdata", i, VEC[i].req), bus_rdata, VEC[i].erd);
            step();
            idle();
            chk($sformatf("table[%0d] R%0d irq_time", i, VEC[i].req), 32'(irq_time), 32'(VEC[i].te));
            chk($sformatf("table[%0d] R%0d irq_buserr", i, VEC[i].req), 32'(irq_buserr), 32'(VEC[i].be));
        end

        // R3 R5: first tick
        sync_tick(); step();
        rd("R3 prescaler wrapped", 4'd2, 0);
        rd("R3 seconds advanced", 4'd0, 1);
        rd("R5 tick event", 4'd5, 1);
        chk("R8 masked event quiet", 32'(irq_time), 0);

        // R8 R6
        wr(4'd7, 1);
        chk("R8 unmasked event raises irq", 32'(irq_time), 1);
        wr(4'd5, 0);
        chk("R6 zero write keeps status", 32'(irq_time), 1);
        wr(4'd5, 1);
        chk("R6 one write clears status", 32'(irq_time), 0);

        // R6 set wins over clear in tick cycle
        sync_tick();
        bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h1;
        step(); idle();
        rd("R6 set beats clear", 4'd5, 1);
        chk("R6 irq after set-wins", 32'(irq_time), 1);
        wr(4'd5, 3);

        // R4 load on next tick
        wr(4'd1, 100);
        rd("R4 load waits for tick", 4'd0, 2);
        sync_tick(); step();
        rd("R4 loaded at tick", 4'd0, 100);
        rd("R2 load word reads live seconds", 4'd1, 100);

        // R5 R8 alarm
        wr(4'd4, 101);
        wr(4'd5, 3);
        wr(4'd8, 1);
        wr(4'd7, 2);
        sync_tick(); step();
        chk("R8 alarm raises irq", 32'(irq_time), 1);
        rd("R5 alarm and tick events", 4'd5, 3);
        wr(4'd5, 1);
        chk("R8 alarm bit still pending", 32'(irq_time), 1);
        wr(4'd5, 2);
        chk("R8 alarm cleared", 32'(irq_time), 0);
        sync_tick(); step();
        rd("R3 seconds after alarm", 4'd0, 102);
        rd("R5 no alarm on mismatch", 4'd5, 1);
        chk("R8 tick masked", 32'(irq_time), 0);
        wr(4'd8, 3);

        // R7 R8 mask changes
        wr(4'd7, 1);
        chk("R8 unmask re-evaluates", 32'(irq_time), 1);
        wr(4'd8, 1);
        chk("R8 mask-set re-evaluates", 32'(irq_time), 0);
        rd("R7 mask after set", 4'd6, 3);

        // R3 seconds wrap
        wr(4'd1, 32'hFFFF_FFFF);
        sync_tick(); step();
        rd("R4 max loaded", 4'd0, 32'hFFFF_FFFF);
        sync_tick(); step();
        rd("R3 seconds wrap to zero", 4'd0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule